// File: doc/BRIEF.md
# GPIO Port with Interrupt Capture

This block is a 32-pin general-purpose I/O port with a small single-cycle register bus. Software drives pins through a stored output word and a direction word (1 = drive). Each of those words can be changed whole, or one pin at a time through set and clear alias addresses, so no read-modify-write is needed. Pin inputs pass through a two-stage synchronizer. The synchronized value can be read back and also feeds the interrupt detectors.

Each pin has its own interrupt detector. A configuration bit selects level or edge sensing. Two control words select the polarity and a both-edges mode. Detected events set bits in a pending register that software clears by writing 1s. An enable mask, changed through its own set and clear aliases, decides which pending bits reach the single combined interrupt line.

Writes commit on the rising clock edge when `bus_wr` is high. Read data is combinational from `bus_addr`.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset, every register and the synchronizer are zero. So `pin_out`, `pin_oe` and `irq` are 0, and every readable register reads 0.
- R2: Byte offsets: output word 0x00, synchronized input 0x04, direction 0x08, polarity control 0x18, both-edge control 0x1C, pending 0x20, level/edge config 0x2C, enable-set 0x30, enable-clear 0x34, output-set 0x40, output-clear 0x44, direction-set 0x48, direction-clear 0x4C. Reads of 0x00, 0x08, 0x18, 0x1C, 0x20 and 0x2C return stored values. Reads of 0x30 return the enable mask. All other offsets, including the output and direction aliases, read 0.
- R3: A write to 0x00 loads the output word. A write to 0x40 sets the output bits that are 1 in the data, and a write to 0x44 clears them. Other bits are kept. `pin_out` equals the output word.
- R4: Writes to 0x48 and 0x4C set and clear direction bits the same way. `pin_oe` equals the direction word, with 1 meaning drive.
- R5: Input 0x04 reads `pin_in` after two clock edges. After one edge it still shows the old value.
- R6: A config bit of 0 (edge) with both control bits 0 sets the pending bit on a rising edge only. The bit is set on the third rising clock edge after the pin changes.
- R7: A config bit of 0 with polarity bit 1 and both-edge bit 0 sets the pending bit on a falling edge only.
- R8: A config bit of 0 with both-edge bit 1 sets the pending bit on both rising and falling edges.
- R9: A config bit of 1 (level) sets the pending bit on every cycle the active level is present: high when the polarity bit is 0, low when it is 1. A clear while the level persists has no lasting effect.
- R10: Writing 1 to a pending bit at 0x20 clears it. Writing 0 leaves it unchanged.
- R11: If an event and a clearing write hit the same pending bit in the same cycle, the bit stays set.
- R12: A write to 0x30 sets the enable bits that are 1 in the data, and a write to 0x34 clears them. `irq` is high exactly when some pending bit is also enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, commits at the rising edge |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pin_in | input | 32 | Pin input levels (asynchronous) |
| pin_out | output | 32 | Pin output levels |
| pin_oe | output | 32 | Pin output enables |
| irq | output | 1 | Combined interrupt |

## Verification
A pin event and a write-1-to-clear on the same pending bit can land in the same cycle. The bench provokes this by timing a clearing write to commit on the very edge at which a synchronized edge reaches the pending register, two edges after it entered the synchronizer. It then judges that the bit reads as still set. Level sensing meets the same collision on every cycle. There, a clear issued while the active level holds must leave the bit set, while the same clear after the level is released must empty it.

// File: rtl/gpio_irq_port.sv
module gpio_irq_port #(
  parameter int NPINS = 32,
  parameter int AW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [NPINS-1:0] bus_wdata,
  output logic [NPINS-1:0] bus_rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  output logic             irq
);
  localparam logic [AW-1:0] A_OUT  = AW'('h00);
  localparam logic [AW-1:0] A_IN   = AW'('h04);
  localparam logic [AW-1:0] A_DIR  = AW'('h08);
  localparam logic [AW-1:0] A_POL  = AW'('h18);
  localparam logic [AW-1:0] A_BOTH = AW'('h1C);
  localparam logic [AW-1:0] A_PEND = AW'('h20);
  localparam logic [AW-1:0] A_LVL  = AW'('h2C);
  localparam logic [AW-1:0] A_ENS  = AW'('h30);
  localparam logic [AW-1:0] A_ENC  = AW'('h34);
  localparam logic [AW-1:0] A_OS   = AW'('h40);
  localparam logic [AW-1:0] A_OC   = AW'('h44);
  localparam logic [AW-1:0] A_DS   = AW'('h48);
  localparam logic [AW-1:0] A_DC   = AW'('h4C);

  logic [NPINS-1:0] out_q, dir_q, pol_q, both_q, lvl_q, pend_q, en_q;
  logic [NPINS-1:0] meta_q, sync_q, prev_q;
  logic [NPINS-1:0] rise, fall, evt, clr;

  function automatic logic hit(input logic [AW-1:0] a);
    return bus_wr && bus_addr == a;
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pin_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end

  assign rise = sync_q & ~prev_q;
  assign fall = ~sync_q & prev_q;

  always_comb
    for (int i = 0; i < NPINS; i++)
      if (lvl_q[i])      evt[i] = pol_q[i] ? ~sync_q[i] : sync_q[i];
      else if (both_q[i]) evt[i] = rise[i] | fall[i];
      else                evt[i] = pol_q[i] ? fall[i] : rise[i];

  assign clr = hit(A_PEND) ? bus_wdata : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      out_q  <= '0;
      dir_q  <= '0;
      pol_q  <= '0;
      both_q <= '0;
      lvl_q  <= '0;
      pend_q <= '0;
      en_q   <= '0;
    end else begin
      if (hit(A_OUT))  out_q  <= bus_wdata;
      if (hit(A_OS))   out_q  <= out_q | bus_wdata;
      if (hit(A_OC))   out_q  <= out_q & ~bus_wdata;
      if (hit(A_DIR))  dir_q  <= bus_wdata;
      if (hit(A_DS))   dir_q  <= dir_q | bus_wdata;
      if (hit(A_DC))   dir_q  <= dir_q & ~bus_wdata;
      if (hit(A_POL))  pol_q  <= bus_wdata;
      if (hit(A_BOTH)) both_q <= bus_wdata;
      if (hit(A_LVL))  lvl_q  <= bus_wdata;
      if (hit(A_ENS))  en_q   <= en_q | bus_wdata;
      if (hit(A_ENC))  en_q   <= en_q & ~bus_wdata;
      pend_q <= (pend_q & ~clr) | evt;
    end

  always_comb
    case (bus_addr)
      A_OUT:   bus_rdata = out_q;
      A_IN:    bus_rdata = sync_q;
      A_DIR:   bus_rdata = dir_q;
      A_POL:   bus_rdata = pol_q;
      A_BOTH:  bus_rdata = both_q;
      A_PEND:  bus_rdata = pend_q;
      A_LVL:   bus_rdata = lvl_q;
      A_ENS:   bus_rdata = en_q;
      default: bus_rdata = '0;
    endcase

  assign pin_out = out_q;
  assign pin_oe  = dir_q;
  assign irq     = |(pend_q & en_q);

  // R3
  out_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit(A_OS) |=> ((pin_out & $past(bus_wdata)) == $past(bus_wdata)));
  // R3
  out_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit(A_OC) |=> ((pin_out & $past(bus_wdata)) == '0));
  // R4
  dir_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit(A_DS) |=> ((pin_oe & $past(bus_wdata)) == $past(bus_wdata)));
  // R4
  dir_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit(A_DC) |=> ((pin_oe & $past(bus_wdata)) == '0));
  // R11
  evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((pend_q & $past(evt)) == $past(evt)));
  // R10
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit(A_PEND) && evt == '0) |=> $stable(pend_q));
  // R12
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq);
endmodule

// File: tb/sim_gpio_irq_port.sv
module sim_gpio_irq_port;
  logic clk = 0, rst_n = 0, bus_wr = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata, pin_in = 0, pin_out, pin_oe;
  logic irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gpio_irq_port u0 (.clk, .rst_n, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
                    .pin_in, .pin_out, .pin_oe, .irq);

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic pins(logic [31:0] v);
    @(negedge clk);
    pin_in = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 pin_out", pin_out, 0);
    chk("R1 pin_oe", pin_oe, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    foreach (u_offs[i]) begin
      rd(u_offs[i], d);
      chk("R1 reg", d, 0);
    end
  endtask

  logic [7:0] u_offs[8] = '{8'h00, 8'h04, 8'h08, 8'h18, 8'h1C, 8'h20, 8'h2C, 8'h30};

  task automatic t_out;
    logic [31:0] d;
    wr(8'h00, 32'hA5A5_0000);
    chk("R3 load", pin_out, 32'hA5A5_0000);
    wr(8'h40, 32'h0000_00FF);
    chk("R3 set", pin_out, 32'hA5A5_00FF);
    wr(8'h44, 32'hA000_000F);
    chk("R3 clr", pin_out, 32'h05A5_00F0);
    rd(8'h00, d);
    chk("R2 out rd", d, 32'h05A5_00F0);
    rd(8'h40, d);
    chk("R2 alias rd", d, 0);
  endtask

  task automatic t_dir;
    logic [31:0] d;
    wr(8'h48, 32'h0F0F);
    chk("R4 set", pin_oe, 32'h0F0F);
    wr(8'h4C, 32'h0003);
    chk("R4 clr", pin_oe, 32'h0F0C);
    rd(8'h08, d);
    chk("R2 dir rd", d, 32'h0F0C);
    rd(8'h50, d);
    chk("R2 unmapped", d, 0);
  endtask

  task automatic t_sync;
    logic [31:0] d;
    @(negedge clk);
    pin_in = 32'h1234_5678;
    @(negedge clk);
    rd(8'h04, d);
    chk("R5 one edge", d, 0);
    @(negedge clk);
    rd(8'h04, d);
    chk("R5 two edges", d, 32'h1234_5678);
    @(negedge clk);
    rd(8'h20, d);
    chk("R6 rising all", d, 32'h1234_5678);
    pins(0);
    rd(8'h20, d);
    chk("R6 no fall", d, 32'h1234_5678);
    wr(8'h20, 32'hFFFF_FFFF);
  endtask

  task automatic t_fall;
    logic [31:0] d;
    wr(8'h18, 32'h20);
    pins(32'h20);
    rd(8'h20, d);
    chk("R7 rise ignored", d, 0);
    pins(0);
    rd(8'h20, d);
    chk("R7 fall", d, 32'h20);
    wr(8'h20, 32'h20);
    wr(8'h18, 0);
  endtask

  task automatic t_both;
    logic [31:0] d;
    wr(8'h1C, 32'h40);
    pins(32'h40);
    rd(8'h20, d);
    chk("R8 rise", d, 32'h40);
    wr(8'h20, 32'h40);
    pins(0);
    rd(8'h20, d);
    chk("R8 fall", d, 32'h40);
    wr(8'h20, 32'h40);
    wr(8'h1C, 0);
  endtask

  task automatic t_level;
    logic [31:0] d;
    wr(8'h2C, 32'h80);
    rd(8'h2C, d);
    chk("R2 cfg rd", d, 32'h80);
    pins(32'h80);
    rd(8'h20, d);
    chk("R9 high", d, 32'h80);
    wr(8'h20, 32'h80);
    rd(8'h20, d);
    chk("R9 persists", d, 32'h80);
    pins(0);
    wr(8'h20, 32'h80);
    rd(8'h20, d);
    chk("R9 released", d, 0);
    wr(8'h18, 32'h80);
    @(negedge clk);
    rd(8'h20, d);
    chk("R9 low level", d, 32'h80);
    wr(8'h18, 0);
    @(negedge clk);
    wr(8'h2C, 0);
    wr(8'h20, 32'h80);
  endtask

  task automatic t_w1c;
    logic [31:0] d;
    pins(32'h0000_0108);
    pins(0);
    wr(8'h20, 0);
    rd(8'h20, d);
    chk("R10 zero write", d, 32'h108);
    wr(8'h20, 32'h100);
    rd(8'h20, d);
    chk("R10 one bit", d, 32'h8);
  endtask

  task automatic t_irq;
    logic [31:0] d;
    chk("R12 disabled", {31'b0, irq}, 0);
    wr(8'h30, 32'h8);
    chk("R12 enabled", {31'b0, irq}, 1);
    rd(8'h30, d);
    chk("R12 en rd", d, 32'h8);
    wr(8'h34, 32'h8);
    chk("R12 cleared", {31'b0, irq}, 0);
    wr(8'h20, 32'h8);
  endtask

  task automatic t_win;
    logic [31:0] d;
    pins(32'h200);
    pins(0);
    @(negedge clk);
    pin_in = 32'h200;
    @(negedge clk);
    @(negedge clk);
    bus_wr = 1; bus_addr = 8'h20; bus_wdata = 32'h200;
    @(negedge clk);
    bus_wr = 0;
    rd(8'h20, d);
    chk("R11 event wins", d, 32'h200);
    wr(8'h20, 32'h200);
    rd(8'h20, d);
    chk("R11 later clear", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_out();
    t_dir();
    t_sync();
    t_fall();
    t_both();
    t_level();
    t_w1c();
    t_irq();
    t_win();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog got=hang exp=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule